// File: doc/BRIEF.md
# External Interrupt Pin Port

This peripheral looks after seven general-purpose pins, indexed 1 through 7, and lets each one act as an external interrupt request source. Index 0 is reserved and always reads as zero. A small synchronous register bus gives software four registers. One sets each pin's detection mode. One sets its direction. One holds output data and returns the pin levels on reads. The last holds the latched edge flags, which are cleared by writing 1.

Each pin gives one request line to a downstream interrupt controller, which does any masking. Level-sensitive mode treats a low pin as an active request and does not latch it. The three edge modes latch a flag that stays set until software clears it. The detection logic watches the level the pin actually carries. As a result, a pin configured as an output can raise its own request when software writes the data register.

Top module: `xirq_port`

## Requirements
- R1: After reset, the mode register (address 0), direction register (address 1) and flag register (address 3) read 0. No pin is an output, and with all pins high no request is asserted.
- R2: Writing the direction register sets bit n to make pin n an output (pin_oe[n]=1). Clearing bit n makes pin n an input. The written value reads back.
- R3: Pin index 0 is reserved. Its direction bit (bit 0) and its mode field (bits 1:0) read as 0 whatever value is written.
- R4: Mode 2'b00, held in bits [2n+1:2n] of the mode register, is level mode. The request equals the inverted pin level, and it drops as soon as the pin returns high, with no flag set.
- R5: Mode 2'b01 detects rising edges. A low-to-high transition sets flag bit n and the request, and both stay set after the pin goes low again. A falling transition sets nothing.
- R6: Mode 2'b10 detects falling edges. A high-to-low transition sets the flag, which remains set after the pin returns high.
- R7: Mode 2'b11 detects both edges. Either transition sets the flag.
- R8: Writing 1 to flag bit n (address 3) clears that flag and its request. Writing 0 leaves it unchanged.
- R9: If an edge is detected in the same cycle as a clear of that flag, the flag stays set.
- R10: With pin n an output, writing the data register (address 2) drives pin_out[n]. A write that produces an edge matching the pin's mode sets its flag.
- R11: Reading the data register returns the output latch for output pins and the synchronized pin level for input pins, with bit 0 read as 0.
- R12: Read data is registered. bus_rdata shows the register selected by bus_addr one clock edge earlier, so back-to-back reads of different addresses return their own values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 mode, 1 direction, 2 data, 3 flags |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Levels seen on the pins from outside |
| pin_out | output | 8 | Output data latch driven to the pins |
| pin_oe | output | 8 | Output enable per pin (1 = output) |
| irq_req | output | 8 | Interrupt request per pin, bit 0 always 0 |

## Verification
Two functions can land on the same clock edge: a software write-1-to-clear of a flag, and the capture of a fresh edge into that same flag. The bench drives a falling transition on a falling-edge pin and counts the two synchronizer stages and the detection stage. It then issues the flag clear so that the clear is captured on exactly the edge where the flag would set. A later read must return the flag still set. A separate clear issued with no edge pending must empty the flag, which shows that the clear itself works.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam logic [1:0] DET_LEVEL = 2'b00;
  localparam logic [1:0] DET_RISE  = 2'b01;
  localparam logic [1:0] DET_FALL  = 2'b10;
  localparam logic [1:0] DET_BOTH  = 2'b11;

  localparam logic [1:0] RA_MODE = 2'd0;
  localparam logic [1:0] RA_DIR  = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_FLAG = 2'd3;

  // Does a transition prev->cur match the selected detection mode?
  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    logic hit;
    case (mode)
      DET_RISE: hit = !prev && cur;
      DET_FALL: hit = prev && !cur;
      DET_BOTH: hit = prev ^ cur;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Request seen by the interrupt controller.
  function automatic logic req_of(input logic [1:0] mode, input logic cur, input logic flag);
    return (mode == DET_LEVEL) ? !cur : flag;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '1;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= stage_q[STAGES-1];
  end

  assign cur = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cur,
  input  logic       prev,
  input  logic       clr,
  output logic       flag_q,
  output logic       irq
);
  logic edge_ev;
  assign edge_ev = edge_hit(mode, prev, cur);

  // A fresh edge outranks a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (edge_ev) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign irq = req_of(mode, cur, flag_q);

  assert_edge_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> flag_q);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_ev) |=> !flag_q);

  assert_flag_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(edge_ev));
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         addr,
  input  logic               we,
  input  logic [2*NPINS-1:0] wdata,
  input  logic [NPINS-1:0]   pin_lvl,
  input  logic [NPINS-1:0]   flag_q,
  output logic [2*NPINS-1:0] mode_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   dout_q,
  output logic [NPINS-1:0]   flag_clr,
  output logic [2*NPINS-1:0] rdata
);
  localparam int DW = 2 * NPINS;
  localparam logic [NPINS-1:0] PMASK = {{(NPINS-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0]    MMASK = {{(DW-2){1'b1}}, 2'b00};

  logic wr_mode, wr_dir, wr_data, wr_flag;
  assign wr_mode = we && (addr == RA_MODE);
  assign wr_dir  = we && (addr == RA_DIR);
  assign wr_data = we && (addr == RA_DATA);
  assign wr_flag = we && (addr == RA_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata & MMASK;
      if (wr_dir)  dir_q  <= wdata[NPINS-1:0] & PMASK;
      if (wr_data) dout_q <= wdata[NPINS-1:0] & PMASK;
    end
  end

  assign flag_clr = wr_flag ? (wdata[NPINS-1:0] & PMASK) : '0;

  logic [NPINS-1:0] pin_view;
  assign pin_view = ((dir_q & dout_q) | (~dir_q & pin_lvl)) & PMASK;

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (addr)
      RA_MODE: rd_mux = mode_q;
      RA_DIR:  rd_mux = {{NPINS{1'b0}}, dir_q};
      RA_DATA: rd_mux = {{NPINS{1'b0}}, pin_view};
      default: rd_mux = {{NPINS{1'b0}}, flag_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == ($past(wdata[NPINS-1:0]) & PMASK)));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00) && !dir_q[0]);
endmodule

// File: rtl/xirq_port.sv
module xirq_port
  import xirq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_we,
  input  logic [2*NPINS-1:0] bus_wdata,
  output logic [2*NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   irq_req
);
  logic [2*NPINS-1:0] mode_q;
  logic [NPINS-1:0]   dir_q, dout_q, flag_clr, flag_q;
  logic [NPINS-1:0]   pad_lvl, cur_lvl, prev_lvl;

  // An output pin carries its own data latch back into the detector.
  assign pad_lvl = (dir_q & dout_q) | (~dir_q & pin_in);

  xirq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_lvl), .cur(cur_lvl), .prev(prev_lvl));

  xirq_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .pin_lvl(cur_lvl), .flag_q(flag_q), .mode_q(mode_q), .dir_q(dir_q),
    .dout_q(dout_q), .flag_clr(flag_clr), .rdata(bus_rdata));

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      if (i == 0) begin : g_rsvd
        assign flag_q[0]  = 1'b0;
        assign irq_req[0] = 1'b0;
      end else begin : g_det
        xirq_detect det_i (
          .clk(clk), .rst_n(rst_n), .mode(mode_q[2*i+1:2*i]),
          .cur(cur_lvl[i]), .prev(prev_lvl[i]), .clr(flag_clr[i]),
          .flag_q(flag_q[i]), .irq(irq_req[i]));

        assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (mode_q[2*i+1:2*i] == DET_LEVEL) |-> (irq_req[i] == !cur_lvl[i]));
      end
    end
  endgenerate

  logic unused_pin0;
  assign unused_pin0 = prev_lvl[0];

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
endmodule

// File: tb/xirq_port_tb_top.sv
module xirq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  pin_out, pin_oe, irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  xirq_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req));

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  // Monitor: results appear right after the next rising edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {8'h00, irq_req} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic irq_chk(input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {8'h00, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic port_chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd_chk(2'd0, 16'h0000, "R1 mode reset");
    rd_chk(2'd1, 16'h0000, "R1 dir reset");
    rd_chk(2'd3, 16'h0000, "R1 flag reset");
    irq_chk(8'h00, "R1 no request");
    port_chk(pin_oe, 8'h00, "R1 oe reset");

    // R3 reserved index 0
    wr(2'd0, 16'hFFFF);
    rd_chk(2'd0, 16'hFFFC, "R3 mode field 0 reads zero");
    wr(2'd0, 16'h0000);
    // R2 direction
    wr(2'd1, 16'h00FF);
    rd_chk(2'd1, 16'h00FE, "R2 R3 dir readback");
    port_chk(pin_oe, 8'hFE, "R2 oe outputs");
    wr(2'd1, 16'h0000);
    port_chk(pin_oe, 8'h00, "R2 oe inputs");
    idle(4);

    // R4 level mode on pin 3
    pin_in[3] = 1'b0; idle(4);
    irq_chk(8'h08, "R4 level active low");
    rd_chk(2'd3, 16'h0000, "R4 no flag in level mode");
    pin_in[3] = 1'b1; idle(4);
    irq_chk(8'h00, "R4 level unlatched");

    // R5 rising edge on pin 2
    wr(2'd0, 16'h0010);
    pin_in[2] = 1'b0; idle(4);
    rd_chk(2'd3, 16'h0000, "R5 falling ignored");
    pin_in[2] = 1'b1; idle(4);
    rd_chk(2'd3, 16'h0004, "R5 rising latched");
    pin_in[2] = 1'b0; idle(4);
    irq_chk(8'h04, "R5 request held");
    pin_in[2] = 1'b1; idle(4);

    // R8 write-1-to-clear
    wr(2'd3, 16'h0000);
    rd_chk(2'd3, 16'h0004, "R8 zero write keeps flag");
    wr(2'd3, 16'h0004);
    rd_chk(2'd3, 16'h0000, "R8 flag cleared");
    irq_chk(8'h00, "R8 request dropped");

    // R6 falling edge on pin 4
    wr(2'd0, 16'h0210);
    pin_in[4] = 1'b0; idle(4);
    pin_in[4] = 1'b1; idle(4);
    rd_chk(2'd3, 16'h0010, "R6 falling latched");
    irq_chk(8'h10, "R6 request held high pin");
    wr(2'd3, 16'h0010);

    // R7 both edges on pin 5
    wr(2'd0, 16'h0E10);
    pin_in[5] = 1'b0; idle(4);
    rd_chk(2'd3, 16'h0020, "R7 falling seen");
    wr(2'd3, 16'h0020);
    rd_chk(2'd3, 16'h0000, "R7 cleared");
    pin_in[5] = 1'b1; idle(4);
    rd_chk(2'd3, 16'h0020, "R7 rising seen");
    wr(2'd3, 16'h0020);

    // R9 edge and clear land on the same edge
    pin_in[4] = 1'b0;
    idle(2);
    wr(2'd3, 16'h0010);
    rd_chk(2'd3, 16'h0010, "R9 edge beats clear");
    pin_in[4] = 1'b1; idle(4);
    wr(2'd3, 16'h0010);
    rd_chk(2'd3, 16'h0000, "R9 later clear works");

    // R10 output-driven edge on pin 6
    wr(2'd2, 16'h0040);
    wr(2'd1, 16'h0040);
    wr(2'd0, 16'h1E10);
    idle(4);
    port_chk(pin_out, 8'h40, "R10 pin_out driven");
    wr(2'd3, 16'h00FE);
    wr(2'd2, 16'h0000); idle(4);
    rd_chk(2'd3, 16'h0000, "R10 falling write ignored");
    wr(2'd2, 16'h0040); idle(4);
    rd_chk(2'd3, 16'h0040, "R10 software edge latched");

    // R11 data readback; R4 with pins 1 and 3 low
    pin_in = 8'hB5; idle(4);
    rd_chk(2'd2, 16'h00F4, "R11 pin data readback");
    irq_chk(8'h4A, "R4 R10 mixed requests");

    // R12 back-to-back reads
    rd_chk(2'd1, 16'h0040, "R12 dir read");
    rd_chk(2'd0, 16'h1E10, "R12 mode read");
    rd_chk(2'd3, 16'h0040, "R12 flag read");
    idle(3);

    finish_run();
  end
endmodule